// File: doc/BRIEF.md
# Line Activity and Collision Tracker

This block watches two line levels that have already been digitized: a receive data line and a collision line. A sampling clock that runs at a fixed multiple of the bit rate strobes both. The block produces two one-bit flags. The carrier flag shows that traffic is present on the receive line. The collision flag shows that activity is present on the collision line. Every time window is a count of sample ticks, and all of the window lengths are parameters.

The carrier flag rises on a rising edge of the receive line. It falls a fixed number of samples after the most recent rising edge. This lets the final bit of a frame be strobed, while a trailing level cannot hold the flag up. After the carrier flag falls, a hold-off window blocks it from rising again. Collision activity counts only when the collision line stays high for a minimum run of samples. Once set, the collision flag is extended for a shorter window that is timed from the rise of the last pulse that qualified.

With the default parameters there are 16 samples per bit. The carrier drop window is 24 samples and the hold-off window is 32 samples. The collision extension is 24 samples, and a collision pulse needs a run of 3 high samples.

Top module: `line_activity_tracker`

## Requirements
- R1: Reset drives both flags low and leaves the hold-off inactive. A rising edge on the first sample after reset is accepted.
- R2: A rising edge is a sample of 1 that follows a sample of 0. The sample before the first sample after reset counts as 0. When the carrier flag is low and no hold-off is running, a rising edge sets the carrier flag at the clock edge that samples it.
- R3: Each rising edge seen while carrier is high restarts the drop window. Carrier falls at the 24th sample after the latest rising edge. If that sample is itself a rising edge, the window restarts instead of ending.
- R4: A receive level held high does not keep carrier up. Carrier falls 24 samples after the rise, and it does not return while the level stays high.
- R5: When carrier falls at sample d, rising edges at samples d+1 through d+32 are ignored and carrier stays low. A rising edge at sample d+33 or later sets carrier again.
- R6: A high run on the collision line that is shorter than 3 consecutive samples never sets the collision flag.
- R7: The collision flag is set at the clock edge that samples the 3rd consecutive high sample of a pulse.
- R8: The collision flag clears at sample r+24, where r is the rising sample of the latest qualified pulse, provided the collision line is low at that sample. A later qualified pulse moves r forward. An unqualified glitch does not move r.
- R9: If the collision line is still high when the extension has run out, the flag holds until the first low sample and clears at that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, a fixed multiple of the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_level_i | input | 1 | Digitized receive line level |
| col_level_i | input | 1 | Digitized collision line level |
| carrier_o | output | 1 | Carrier present on the receive line |
| collision_o | output | 1 | Collision present |

## Verification
The bench places rising edges at the exact sample on each side of each window boundary. It puts one at the 24th sample after a rise, one at the last hold-off sample, and one at the first sample after the hold-off. A design off by one in either counter would drop carrier a sample early or late, or would accept or miss the boundary edge. A receive level held high is used to catch a design that tracks the level rather than its edges, which would keep carrier up indefinitely. Collision stimuli include glitches of one and two samples, a glitch inside a running extension, and a line held past expiry. These expose a design that sets on short pulses, restarts the extension on glitches, or drops the flag while the line is still high.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [1:0] {
    CRS_IDLE = 2'd0,
    CRS_ON   = 2'd1,
    CRS_HOLD = 2'd2
  } crs_state_e;
endpackage

// File: rtl/lat_rise_det.sv
module lat_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/lat_carrier_trk.sv
module lat_carrier_trk
  import lat_pkg::*;
#(
  parameter int unsigned DROP_SAMPLES = 24,
  parameter int unsigned HOLD_SAMPLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic carrier_o
);
  localparam int unsigned CNT_MAX = (DROP_SAMPLES > HOLD_SAMPLES) ? DROP_SAMPLES : HOLD_SAMPLES;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] DROP_LAST = CW'(DROP_SAMPLES - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_SAMPLES - 1);

  crs_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          carrier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CRS_IDLE;
      cnt_q     <= '0;
      carrier_q <= 1'b0;
    end else begin
      case (state_q)
        CRS_IDLE: begin
          if (rise_i) begin
            state_q   <= CRS_ON;
            carrier_q <= 1'b1;
            cnt_q     <= '0;
          end
        end
        CRS_ON: begin
          if (rise_i) begin
            cnt_q <= '0;                 // restart drop window
          end else if (cnt_q == DROP_LAST) begin
            state_q   <= CRS_HOLD;
            carrier_q <= 1'b0;
            cnt_q     <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        CRS_HOLD: begin
          if (cnt_q == HOLD_LAST) begin
            state_q <= CRS_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q   <= CRS_IDLE;
          carrier_q <= 1'b0;
          cnt_q     <= '0;
        end
      endcase
    end
  end

  assign carrier_o = carrier_q;

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CRS_IDLE && rise_i) |=> carrier_o);

  assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carrier_o && rise_i) |=> carrier_o);

  assert_drop_no_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(carrier_o) |-> !$past(rise_i));

  assert_holdoff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CRS_HOLD) |=> !carrier_o);
endmodule

// File: rtl/lat_collision_trk.sv
module lat_collision_trk #(
  parameter int unsigned MIN_HIGH    = 3,
  parameter int unsigned EXT_SAMPLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic col_i,
  output logic collision_o
);
  localparam int unsigned RW = $clog2(MIN_HIGH + 1);
  localparam int unsigned EW = $clog2(EXT_SAMPLES);
  localparam logic [RW-1:0] RUN_QUAL = RW'(MIN_HIGH - 1);
  localparam logic [RW-1:0] RUN_SAT  = RW'(MIN_HIGH);
  localparam logic [EW-1:0] EXT_INIT = EW'(MIN_HIGH - 1);
  localparam logic [EW-1:0] EXT_LAST = EW'(EXT_SAMPLES - 1);

  logic [RW-1:0] run_q;
  logic [EW-1:0] ext_q;
  logic          flag_q;
  logic          qual;

  assign qual = col_i && (run_q == RUN_QUAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                run_q <= '0;
    else if (!col_i)            run_q <= '0;
    else if (run_q != RUN_SAT)  run_q <= run_q + 1'b1;
  end

  // ext_q counts samples since the rise of the last qualified pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ext_q  <= '0;
    end else if (qual) begin
      flag_q <= 1'b1;
      ext_q  <= EXT_INIT;
    end else if (flag_q) begin
      if (ext_q == EXT_LAST) begin
        if (!col_i) flag_q <= 1'b0;
      end else begin
        ext_q <= ext_q + 1'b1;
      end
    end
  end

  assign collision_o = flag_q;

  assert_qualify_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual |=> collision_o);

  assert_no_glitch_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(collision_o) |-> ($past(col_i) && $past(run_q) == RUN_QUAL));

  assert_hold_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collision_o && col_i) |=> collision_o);

  assert_clear_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(collision_o) |-> !$past(col_i));
endmodule

// File: rtl/line_activity_tracker.sv
module line_activity_tracker #(
  parameter int unsigned BIT_SAMPLES   = 16,
  parameter int unsigned DROP_SAMPLES  = BIT_SAMPLES * 3 / 2,
  parameter int unsigned HOLD_SAMPLES  = BIT_SAMPLES * 2,
  parameter int unsigned CLSN_EXT      = BIT_SAMPLES * 3 / 2,
  parameter int unsigned CLSN_MIN_HIGH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_level_i,
  input  logic col_level_i,
  output logic carrier_o,
  output logic collision_o
);
  logic rx_rise;

  lat_rise_det u_rx_rise (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (rx_level_i),
    .rise_o  (rx_rise)
  );

  lat_carrier_trk #(
    .DROP_SAMPLES (DROP_SAMPLES),
    .HOLD_SAMPLES (HOLD_SAMPLES)
  ) u_carrier (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rx_rise),
    .carrier_o (carrier_o)
  );

  lat_collision_trk #(
    .MIN_HIGH    (CLSN_MIN_HIGH),
    .EXT_SAMPLES (CLSN_EXT)
  ) u_collision (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .col_i       (col_level_i),
    .collision_o (collision_o)
  );
endmodule

// File: tb/line_activity_tracker_tb.sv
module line_activity_tracker_tb;
  localparam int DROP = 24;
  localparam int HOLD = 32;
  localparam int EXT  = 24;
  localparam int MINH = 3;

  typedef struct {
    logic  crs;
    logic  col;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_i = 1'b0;
  logic col_i = 1'b0;
  logic carrier_o, collision_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  // expectation state, expressed in sample slots
  int   n = 0;
  logic m_prev = 1'b0;
  logic m_crs = 1'b0;
  int   m_last = 0;
  int   m_drop = -1000;
  int   m_run = 0;
  logic m_col = 1'b0;
  int   m_crise = 0;

  always #4 clk = ~clk;

  line_activity_tracker u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rx_level_i  (rx_i),
    .col_level_i (col_i),
    .carrier_o   (carrier_o),
    .collision_o (collision_o)
  );

  task automatic step(input logic rx, input logic col, input string tag);
    logic rise;
    logic qual;
    exp_t e;
    @(negedge clk);
    rx_i  = rx;
    col_i = col;
    rise = rx && !m_prev;
    m_prev = rx;
    if (m_crs) begin
      if (rise) m_last = n;                       // R3 restart
      else if (n - m_last >= DROP) begin m_crs = 1'b0; m_drop = n; end
    end else if (rise && (n - m_drop > HOLD)) begin // R2, R5
      m_crs = 1'b1;
      m_last = n;
    end
    qual = col && (m_run == MINH - 1);
    if (!col) m_run = 0;
    else if (m_run < MINH) m_run++;
    if (qual) begin m_col = 1'b1; m_crise = n - MINH + 1; end
    else if (m_col && (n - m_crise >= EXT) && !col) m_col = 1'b0;
    e.crs = m_crs;
    e.col = m_col;
    e.tag = tag;
    q.push_back(e);
    n++;
  endtask

  task automatic run(input logic rx, input logic col, input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) step(rx, col, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (carrier_o !== e.crs || collision_o !== e.col) begin
        fails++;
        $display("FAIL %s slot-check: carrier=%b collision=%b expected carrier=%b collision=%b",
                 e.tag, carrier_o, collision_o, e.crs, e.col);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (carrier_o !== 1'b0 || collision_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: carrier=%b collision=%b expected 0 0", carrier_o, collision_o);
    end
    rst_ni = 1'b1;

    // R1: a rise on the very first sample after reset is accepted
    run(1'b1, 1'b0, 8, "R1");
    run(1'b0, 1'b0, 70, "R1");

    // R2: single isolated pulse
    run(1'b0, 1'b0, 5, "R2");
    run(1'b1, 1'b0, 8, "R2");
    run(1'b0, 1'b0, 70, "R2");

    // R3: bit stream, each rise restarts the window
    for (int k = 0; k < 6; k++) begin
      run(1'b1, 1'b0, 8, "R3");
      run(1'b0, 1'b0, 8, "R3");
    end
    run(1'b0, 1'b0, 70, "R3");
    run(1'b1, 1'b0, 4, "R3");
    run(1'b0, 1'b0, 20, "R3");
    run(1'b1, 1'b0, 4, "R3");
    run(1'b0, 1'b0, 70, "R3");
    // rise exactly on the drop sample restarts the window
    run(1'b1, 1'b0, 1, "R3");
    run(1'b0, 1'b0, 23, "R3");
    run(1'b1, 1'b0, 1, "R3");
    run(1'b0, 1'b0, 70, "R3");

    // R4: level held high
    run(1'b1, 1'b0, 100, "R4");
    run(1'b0, 1'b0, 70, "R4");

    // R5: rises inside hold-off, at last hold-off sample, then just after
    run(1'b1, 1'b0, 1, "R5");
    run(1'b0, 1'b0, 28, "R5");
    run(1'b1, 1'b0, 3, "R5");
    run(1'b0, 1'b0, 24, "R5");
    run(1'b1, 1'b0, 1, "R5");
    run(1'b0, 1'b0, 70, "R5");
    run(1'b1, 1'b0, 1, "R5");
    run(1'b0, 1'b0, 56, "R5");
    run(1'b1, 1'b0, 1, "R5");
    run(1'b0, 1'b0, 70, "R5");

    // R6: glitches of one and two samples
    run(1'b0, 1'b1, 1, "R6");
    run(1'b0, 1'b0, 5, "R6");
    run(1'b0, 1'b1, 2, "R6");
    run(1'b0, 1'b0, 40, "R6");

    // R7: minimal qualified pulse, then R8 expiry
    run(1'b0, 1'b1, 3, "R7");
    run(1'b0, 1'b0, 40, "R8");

    // R8: pulse train extends, glitch inside extension does not
    for (int k = 0; k < 5; k++) begin
      run(1'b0, 1'b1, 4, "R8");
      run(1'b0, 1'b0, 12, "R8");
    end
    run(1'b0, 1'b1, 4, "R8");
    run(1'b0, 1'b0, 10, "R8");
    run(1'b0, 1'b1, 2, "R8");
    run(1'b0, 1'b0, 40, "R8");

    // R9: line high past expiry
    run(1'b0, 1'b1, 60, "R9");
    run(1'b0, 1'b0, 40, "R9");
    run(1'b0, 1'b1, 25, "R9");
    run(1'b0, 1'b0, 40, "R9");

    // both channels active together
    for (int k = 0; k < 8; k++) begin
      run(1'b1, 1'b1, 8, "R3");
      run(1'b0, 1'b0, 8, "R8");
    end
    run(1'b0, 1'b0, 80, "R8");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule